// File: doc/BRIEF.md
# Power-Up Register Initializer

This block loads default settings into three volatile slave chips that share a three-wire serial link: two analog front-end chips and one timing-generator chip. None of these chips keeps its settings without power. Every register therefore has to be written again after power-up and after each press of the board reset button. The block runs on its own, with no host involved. When it has finished it raises a done flag.

An internal constant table lists every register entry. The front-end chip 0 entries come first, then the front-end chip 1 entries, then the timing-generator entries. A counter steps through the table. For each entry the block builds a 16-bit frame and splits it into two bytes. It passes each byte through an 8-bit shift register to the serial data line, while it drives the serial clock and the active-low load strobe of the chip being addressed.

Several timing-generator defaults come from an 8-bit switch input and a 16-bit digital I/O input. The block samples both inputs once, when a sequence starts, so every frame in that sequence uses the same values.

Top module: `reg_init_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, init_done_o is 0, every bit of sel_no is 1, and sclk_o and sdata_o are 0. The sequence then starts by itself.
- R2: While restart_i is 1, the block stays in its start state: init_done_o is 0 and all outputs are idle. This also aborts any frame in progress. In the first clock after restart_i returns to 0, the block samples its inputs and then starts again from entry 0.
- R3: There are N_FE=4 entries for front-end chip 0 (sel_no[0]), then 4 for front-end chip 1 (sel_no[1]), then N_TG=6 for the timing generator (sel_no[2]), in that order. During the frame of an entry, only the strobe of that entry's chip is low.
- R4: Each entry takes 34 cycles. The first cycle is idle, the next 32 cycles form the frame with the strobe low, and the last cycle is idle. In frame cycle j (0..31), sclk_o equals j mod 2. At most one strobe is low at any time, and sclk_o is high only inside a frame.
- R5: Serial bit n (0..15) is driven on sdata_o during frame cycles 2n and 2n+1, so the data line is stable while sclk_o is high. The bit order is: the write bit (always 0), then the address bits a0..a3, then the data bits d0..d10.
- R6: Entry k (0..3) of front-end chip c (0 or 1) has address k and data 64 + 16*c + k.
- R7: Timing-generator entry k has address k. Its data is {3'b000, sw} for k=0, dio[10:0] for k=1, {6'b0, dio[15:11]} for k=2, and 512 + k for k of 3 or more.
- R8: The sw and dio values used in a sequence are the ones present at the start clock. Changes to sw_i or dio_i after that clock have no effect until the next start.
- R9: init_done_o goes to 1 in the cycle after the last entry's trailing idle cycle. It stays at 1, with all outputs idle, until rst_ni or restart_i is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Board reset button, synchronous, active high |
| sw_i | input | 8 | Switch inputs that select defaults |
| dio_i | input | 16 | Digital I/O inputs that select defaults |
| sel_no | output | 3 | Load strobes, one per chip, active low |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| init_done_o | output | 1 | All chips programmed |

## Verification
A fault in the entry counter or the shift register shows within one bit period. A wrong bit appears on sdata_o, or a strobe goes low for the wrong chip. A fault in the bit or byte counter shifts the frame length away from 34 cycles, and the sclk_o or strobe edges show it in that same entry. A fault in input capture or restart handling shows only in the timing-generator frames or in the cycle after restart_i falls. For that reason the bench changes sw_i and dio_i in the middle of a sequence and aborts a frame partway through.

// File: rtl/init_pkg.sv
package init_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_LOAD,
    ST_SHIFT,
    ST_GAP,
    ST_DONE
  } init_st_e;

  localparam int unsigned FRAME_W = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_DEV   = 3;
endpackage

// File: rtl/init_entry_rom.sv
module init_entry_rom
  import init_pkg::*;
#(
  parameter int unsigned N_FE  = 4,
  parameter int unsigned N_TG  = 6,
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [7:0]         sw_i,
  input  logic [15:0]        dio_i,
  output logic [1:0]         dev_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [IDX_W-1:0] k;
  logic [10:0]      data;

  always_comb begin
    if (32'(idx_i) < N_FE) begin
      dev_o = 2'd0;
      k     = idx_i;
    end else if (32'(idx_i) < 2 * N_FE) begin
      dev_o = 2'd1;
      k     = idx_i - IDX_W'(N_FE);
    end else begin
      dev_o = 2'd2;
      k     = idx_i - IDX_W'(2 * N_FE);
    end
    if (dev_o != 2'd2) begin
      data = 11'd64 + (dev_o == 2'd1 ? 11'd16 : 11'd0) + 11'(k);
    end else begin
      case (k)
        IDX_W'(0): data = {3'b000, sw_i};
        IDX_W'(1): data = dio_i[10:0];
        IDX_W'(2): data = {6'b0, dio_i[15:11]};
        default:   data = 11'h200 + 11'(k);
      endcase
    end
    // bit 0 leaves first: write bit, address LSB first, data LSB first
    frame_o = {data, 4'(k), 1'b0};
  end
endmodule

// File: rtl/init_byte_shifter.sv
module init_byte_shifter
  import init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              shift_i,
  output logic              bit_o
);
  logic [BYTE_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= byte_i;
    else if (shift_i) sreg_q <= {1'b0, sreg_q[BYTE_W-1:1]};
  end

  assign bit_o = sreg_q[0];
endmodule

// File: rtl/init_ctrl.sv
module init_ctrl
  import init_pkg::*;
#(
  parameter int unsigned N_ENT = 14,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output init_st_e         st_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             phase_o,
  output logic             capture_o,
  output logic             load_o,
  output logic             hi_load_o,
  output logic             shift_o
);
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  init_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [BIT_W-1:0] bit_q;
  logic             phase_q, hi_q;
  logic             last_bit;

  assign last_bit = (bit_q == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_START; idx_q <= '0; bit_q <= '0; phase_q <= 1'b0; hi_q <= 1'b0;
    end else if (restart_i) begin
      st_q <= ST_START; idx_q <= '0; bit_q <= '0; phase_q <= 1'b0; hi_q <= 1'b0;
    end else begin
      case (st_q)
        ST_START: begin
          st_q  <= ST_LOAD;
          idx_q <= '0;
        end
        ST_LOAD: begin
          st_q <= ST_SHIFT; bit_q <= '0; phase_q <= 1'b0; hi_q <= 1'b0;
        end
        ST_SHIFT: begin
          phase_q <= ~phase_q;
          if (phase_q) begin
            if (last_bit) begin
              bit_q <= '0;
              if (hi_q) st_q <= ST_GAP;
              else      hi_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (idx_q == IDX_W'(N_ENT - 1)) st_q <= ST_DONE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_LOAD;
          end
        end
        default: st_q <= ST_DONE;
      endcase
    end
  end

  assign st_o      = st_q;
  assign idx_o     = idx_q;
  assign phase_o   = phase_q;
  assign capture_o = (st_q == ST_START) && !restart_i;
  assign hi_load_o = (st_q == ST_SHIFT) && phase_q && last_bit && !hi_q;
  assign load_o    = (st_q == ST_LOAD) || hi_load_o;
  assign shift_o   = (st_q == ST_SHIFT) && phase_q && !last_bit;
endmodule

// File: rtl/reg_init_seq.sv
module reg_init_seq
  import init_pkg::*;
#(
  parameter int unsigned N_FE = 4,
  parameter int unsigned N_TG = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [7:0] sw_i,
  input  logic [15:0] dio_i,
  output logic [2:0] sel_no,
  output logic       sclk_o,
  output logic       sdata_o,
  output logic       init_done_o
);
  localparam int unsigned N_ENT = 2 * N_FE + N_TG;
  localparam int unsigned IDX_W = $clog2(N_ENT);

  init_st_e         st;
  logic [IDX_W-1:0] idx;
  logic             phase, capture, load, hi_load, shift, ser_bit;
  logic [1:0]       dev;
  logic [FRAME_W-1:0] frame;
  logic [7:0]       sw_q;
  logic [15:0]      dio_q;
  logic             in_frame;

  // defaults frozen for the whole sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q <= '0; dio_q <= '0;
    end else if (capture) begin
      sw_q <= sw_i; dio_q <= dio_i;
    end
  end

  init_ctrl #(.N_ENT(N_ENT), .IDX_W(IDX_W)) i_ctrl (
    .clk_i, .rst_ni, .restart_i,
    .st_o(st), .idx_o(idx), .phase_o(phase), .capture_o(capture),
    .load_o(load), .hi_load_o(hi_load), .shift_o(shift)
  );

  init_entry_rom #(.N_FE(N_FE), .N_TG(N_TG), .IDX_W(IDX_W)) i_rom (
    .idx_i(idx), .sw_i(sw_q), .dio_i(dio_q), .dev_o(dev), .frame_o(frame)
  );

  init_byte_shifter i_shift (
    .clk_i, .rst_ni, .load_i(load),
    .byte_i(hi_load ? frame[FRAME_W-1:BYTE_W] : frame[BYTE_W-1:0]),
    .shift_i(shift), .bit_o(ser_bit)
  );

  assign in_frame = (st == ST_SHIFT);

  for (genvar d = 0; d < N_DEV; d++) begin : g_sel
    assign sel_no[d] = !(in_frame && dev == 2'(d));
  end

  assign sclk_o      = in_frame && phase;
  assign sdata_o     = in_frame && ser_bit;
  assign init_done_o = (st == ST_DONE);
endmodule

// File: rtl/init_chk.sv
module init_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       restart_i,
  input logic [2:0] sel_n_i,
  input logic       sclk_i,
  input logic       sdata_i,
  input logic       done_i
);
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~sel_n_i) <= 1);
  a_r4_clk_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_i |-> sel_n_i != 3'b111);
  a_r5_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_i |-> $stable(sdata_i));
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (sel_n_i == 3'b111) && !sclk_i && !sdata_i);
  a_r9_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !restart_i |=> done_i);
  a_r2_restart_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_i && (sel_n_i == 3'b111) && !sclk_i);
endmodule

bind reg_init_seq init_chk i_init_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i),
  .sel_n_i(sel_no), .sclk_i(sclk_o), .sdata_i(sdata_o), .done_i(init_done_o)
);

// File: tb/test_reg_init_seq.sv
module test_reg_init_seq;
  localparam int ENT   = 14;
  localparam int PER   = 34;
  localparam int TOTAL = ENT * PER;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0;
  logic [7:0]  sw  = 8'h00;
  logic [15:0] dio = 16'h0000;
  logic [2:0]  sel_n;
  logic sclk, sdata, done;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int mt = -1;
  logic [7:0]  m_sw  = '0;
  logic [15:0] m_dio = '0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  reg_init_seq i_reg_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .sw_i(sw), .dio_i(dio),
    .sel_no(sel_n), .sclk_o(sclk), .sdata_o(sdata), .init_done_o(done)
  );

  function automatic logic [15:0] exp_word(int e, logic [7:0] s, logic [15:0] d);
    int c, k;
    logic [10:0] v;
    c = e / 4;
    k = (c < 2) ? e % 4 : e - 8;
    if (c < 2) v = 11'(64 + 16 * c + k);              // R6
    else if (k == 0) v = {3'b000, s};                 // R7
    else if (k == 1) v = d[10:0];
    else if (k == 2) v = {6'b0, d[15:11]};
    else v = 11'(512 + k);
    return {v, 4'(k), 1'b0};                          // R5 order
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference: cycles since the start clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mt = -1;
    else begin
      cyc++;
      if (restart) mt = -1;
      else if (mt == -1) begin mt = 0; m_sw = sw; m_dio = dio; end
      else if (mt < TOTAL) mt++;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      logic [2:0] e_sel;
      logic e_sclk, e_sdata, e_done;
      int e, r, dv;
      e_sel = 3'b111; e_sclk = 0; e_sdata = 0; e_done = (mt == TOTAL); dv = 0;
      if (mt >= 0 && mt < TOTAL) begin
        e = mt / PER; r = mt % PER; dv = (e < 8) ? e / 4 : 2;
        if (r >= 1 && r <= 32) begin
          e_sel[dv] = 1'b0;
          e_sclk  = ((r - 1) % 2) == 1;
          e_sdata = exp_word(e, m_sw, m_dio)[(r - 1) / 2];
        end
      end
      chk(sel_n == e_sel, (mt < 0) ? "R2" : "R3", sel_n, e_sel);
      chk(sclk == e_sclk, (mt < 0) ? "R2" : "R4", sclk, e_sclk);
      chk(sdata == e_sdata, (dv < 2) ? "R5/R6" : "R7/R8", sdata, e_sdata);
      chk(done == e_done, (mt < 0) ? "R2" : "R9", done, e_done);
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    sw = 8'hA5; dio = 16'hBEEF;
    repeat (3) @(negedge clk);
    // R1 idle in reset
    chk(done == 0 && sel_n == 3'b111 && !sclk && !sdata, "R1", {done, sel_n, sclk, sdata}, 5'b01110);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    chk(done == 0 && sel_n == 3'b111, "R1", {done, sel_n}, 4'b0111);
    repeat (100) @(negedge clk);
    sw = 8'h00; dio = 16'h0000;                       // R8: must not reach the frames
    repeat (TOTAL + 20) @(negedge clk);
    chk(done == 1'b1, "R9", done, 1);
    restart = 1'b1;                                   // R2 held press
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R2", done, 0);
    sw = 8'h3C; dio = 16'h1234;
    restart = 1'b0;
    repeat (301) @(negedge clk);
    restart = 1'b1;                                   // R2 abort mid-frame
    @(negedge clk);
    restart = 1'b0;
    sw = 8'hF0; dio = 16'h8421;
    repeat (TOTAL + 20) @(negedge clk);
    chk(done == 1'b1, "R9", done, 1);
    finish_run();
  end
endmodule